// File: doc/BRIEF.md
# Condition flags and predicate evaluator

This block keeps the four arithmetic status flags (negative, zero, carry, overflow) for an execute stage and decides, for each instruction, whether it is allowed to take effect. The instruction's 4-bit condition field is tested against the flags that are already committed. The result is a single execute signal. Downstream logic uses it to suppress register writeback and memory side effects.

The datapath presents new flag values together with an update request. The flag register takes them on the next clock edge only if the predicate passes for the same instruction. A suppressed instruction therefore leaves the flags untouched. Compare and test operations always request a flag update and drive no register write.

Top module: `cond_flags_unit`

## Requirements
- R1: After reset is asserted (rst_ni low), flags_o reads 4'b0000. The bit order is {N,Z,C,V}, with N at bit 3 and V at bit 0.
- R2: The encodings 0000 EQ and 0001 NE pass when Z is 1 and when Z is 0, respectively.
- R3: The encodings 0010 (carry set, unsigned higher-or-same) and 0011 (carry clear, unsigned lower) pass when C is 1 and when C is 0, respectively.
- R4: The encodings 0100 MI and 0101 PL pass when N is 1 and when N is 0. The encodings 0110 VS and 0111 VC pass when V is 1 and when V is 0.
- R5: The encoding 1000 HI passes when C is 1 and Z is 0. The encoding 1001 LS passes when C is 0 or Z is 1.
- R6: The encoding 1010 GE passes when N equals V, and 1011 LT passes when N differs from V. The encoding 1100 GT passes when Z is 0 and N equals V. The encoding 1101 LE passes when Z is 1 or N differs from V.
- R7: The encoding 1110 always passes, and the encoding 1111 never passes, whatever the flags hold.
- R8: exec_o is combinational. It reflects the flags committed before the current cycle's edge, with no added latency.
- R9: When flag_we_i is 1 and exec_o is 1, flags_o equals flags_new_i one clock edge later.
- R10: When exec_o is 0, flags_o does not change at the next edge, even if flag_we_i is 1.
- R11: When flag_we_i is 0, flags_o does not change.
- R12: The cond_i input carries bits 31 to 28 of the instruction word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cond_i | input | 4 | Condition field of the instruction (instruction bits 31:28) |
| flag_we_i | input | 1 | The instruction requests a flag update |
| flags_new_i | input | 4 | New flag values {N,Z,C,V} from the datapath |
| exec_o | output | 1 | The predicate passes, so the instruction executes |
| flags_o | output | 4 | Committed flags {N,Z,C,V} |

## Verification
A corrupted flag register appears on flags_o straight away. It also appears on exec_o in the same cycle for every condition that depends on the corrupted bit. A wrong update gate is different: it first shows one edge after a suppressed write, as a changed flags_o. The bench loads every one of the 16 flag states through the normal write path. For each state it evaluates all 16 condition codes against an independently computed truth table. It then tries a write under every condition code, with the update request both on and off, and checks the flags after the edge.

// File: rtl/cond_flags_pkg.sv
package cond_flags_pkg;
  localparam int unsigned COND_W = 4;
  localparam int unsigned FLAG_W = 4;
  localparam int unsigned COND_MSB = 31;
  localparam int unsigned COND_LSB = COND_MSB - COND_W + 1;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } flags_t;

  typedef enum logic [COND_W-1:0] {
    CC_EQ = 4'b0000, CC_NE = 4'b0001, CC_HS = 4'b0010, CC_LO = 4'b0011,
    CC_MI = 4'b0100, CC_PL = 4'b0101, CC_VS = 4'b0110, CC_VC = 4'b0111,
    CC_HI = 4'b1000, CC_LS = 4'b1001, CC_GE = 4'b1010, CC_LT = 4'b1011,
    CC_GT = 4'b1100, CC_LE = 4'b1101, CC_AL = 4'b1110, CC_NV = 4'b1111
  } cond_e;
endpackage

// File: rtl/cond_eval.sv
module cond_eval
  import cond_flags_pkg::*;
(
  input  logic [COND_W-1:0] cond_i,
  input  flags_t            flags_i,
  output logic              pass_o
);
  // Even/odd pairs are complements; bit 0 inverts the base test.
  logic base;
  always_comb begin
    unique case (cond_i[COND_W-1:1])
      3'd0: base = flags_i.z;
      3'd1: base = flags_i.c;
      3'd2: base = flags_i.n;
      3'd3: base = flags_i.v;
      3'd4: base = flags_i.c & ~flags_i.z;
      3'd5: base = ~(flags_i.n ^ flags_i.v);
      3'd6: base = ~flags_i.z & ~(flags_i.n ^ flags_i.v);
      default: base = 1'b1;
    endcase
  end
  assign pass_o = base ^ cond_i[0];
endmodule

// File: rtl/flag_reg.sv
module flag_reg
  import cond_flags_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   wr_i,
  input  flags_t d_i,
  output flags_t q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= '0;
    else if (wr_i) q_o <= d_i;
  end
endmodule

// File: rtl/cond_flags_unit.sv
module cond_flags_unit
  import cond_flags_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [COND_W-1:0] cond_i,
  input  logic              flag_we_i,
  input  logic [FLAG_W-1:0] flags_new_i,
  output logic              exec_o,
  output logic [FLAG_W-1:0] flags_o
);
  flags_t cur_q;
  logic   pass;

  cond_eval u_eval (
    .cond_i (cond_i),
    .flags_i(cur_q),
    .pass_o (pass)
  );

  // Suppressed instructions never touch the flags.
  flag_reg u_flags (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .wr_i  (flag_we_i & pass),
    .d_i   (flags_t'(flags_new_i)),
    .q_o   (cur_q)
  );

  assign exec_o  = pass;
  assign flags_o = cur_q;
endmodule

// File: rtl/cond_flags_unit_chk.sv
module cond_flags_unit_chk
  import cond_flags_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic [COND_W-1:0] cond_i,
  input logic              flag_we_i,
  input logic [FLAG_W-1:0] flags_new_i,
  input logic              exec_o,
  input logic [FLAG_W-1:0] flags_o
);
  AST_WRITE_TAKEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_we_i && exec_o) |=> (flags_o == $past(flags_new_i))); // R9
  AST_SUPPRESS_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !exec_o |=> $stable(flags_o)); // R10
  AST_NO_WE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !flag_we_i |=> $stable(flags_o)); // R11
  AST_ALWAYS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cond_i == 4'b1110) |-> exec_o); // R7
  AST_NEVER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cond_i == 4'b1111) |-> !exec_o); // R7
  AST_EQ_Z: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cond_i == 4'b0000) |-> (exec_o == flags_o[2])); // R2
  AST_GE_NV: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cond_i == 4'b1010) |-> (exec_o == (flags_o[3] == flags_o[0]))); // R6
endmodule

bind cond_flags_unit cond_flags_unit_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cond_i(cond_i), .flag_we_i(flag_we_i),
  .flags_new_i(flags_new_i), .exec_o(exec_o), .flags_o(flags_o)
);

// File: tb/cond_flags_unit_tb.sv
`timescale 1ns/1ps
module cond_flags_unit_tb;
  logic       clk_i = 0;
  logic       rst_ni = 0;
  logic [3:0] cond_i = 4'he;
  logic       flag_we_i = 0;
  logic [3:0] flags_new_i = 0;
  logic       exec_o;
  logic [3:0] flags_o;
  int n_run = 0, n_fail = 0;

  always #5 clk_i = ~clk_i;

  cond_flags_unit u_dut (.*);

  function automatic logic model(input logic [3:0] c, input logic [3:0] f);
    logic n, z, cy, v;
    {n, z, cy, v} = f;
    case (c)
      4'd0: return z;        4'd1: return !z;
      4'd2: return cy;       4'd3: return !cy;
      4'd4: return n;        4'd5: return !n;
      4'd6: return v;        4'd7: return !v;
      4'd8: return cy && !z; 4'd9: return !cy || z;
      4'd10: return n == v;  4'd11: return n != v;
      4'd12: return !z && (n == v);
      4'd13: return z || (n != v);
      4'd14: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic string rtag(input logic [3:0] c);
    case (c)
      4'd0, 4'd1: return "R2";
      4'd2, 4'd3: return "R3";
      4'd4, 4'd5, 4'd6, 4'd7: return "R4";
      4'd8, 4'd9: return "R5";
      4'd14, 4'd15: return "R7";
      default: return "R6";
    endcase
  endfunction

  task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // Load flags through the AL path; the write is sampled mid-cycle.
  task automatic load(input logic [3:0] f);
    @(negedge clk_i);
    cond_i = 4'he; flag_we_i = 1; flags_new_i = f;
    @(negedge clk_i);
    flag_we_i = 0;
  endtask

  initial begin
    #200000;
    n_run++; n_fail++;
    $display("FAIL watchdog act=0 exp=1");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] instr;
    #12;
    chk("R1", flags_o, 4'h0);
    rst_ni = 1;
    // R12: the condition comes from the top four bits of an instruction word
    instr = 32'h1A2B_3C4D;
    @(negedge clk_i); cond_i = instr[31:28]; #1;
    chk("R12", {3'b0, exec_o}, {3'b0, model(4'h1, 4'h0)});
    // R8: the predicate settles in the same cycle against the committed flags
    for (int f = 0; f < 16; f++) begin
      load(4'(f));
      chk("R9", flags_o, 4'(f));
      for (int c = 0; c < 16; c++) begin
        cond_i = 4'(c); #1;
        chk(rtag(4'(c)), {3'b0, exec_o}, {3'b0, model(4'(c), 4'(f))});
      end
    end
    // Gated writes: R9 when the predicate passes, R10 when it fails, R11 when disabled
    for (int f = 0; f < 16; f++) begin
      for (int c = 0; c < 16; c++) begin
        for (int we = 0; we < 2; we++) begin
          logic [3:0] nv, expf;
          load(4'(f));
          nv = ~4'(f);
          cond_i = 4'(c); flag_we_i = we[0]; flags_new_i = nv;
          expf = (we == 1 && model(4'(c), 4'(f))) ? nv : 4'(f);
          @(negedge clk_i);
          flag_we_i = 0;
          chk(we == 0 ? "R11" : (model(4'(c), 4'(f)) ? "R9" : "R10"), flags_o, expf);
        end
      end
    end
    // R1: an asynchronous reset clears nonzero flags
    load(4'hf);
    #2 rst_ni = 0; #1;
    chk("R1", flags_o, 4'h0);
    rst_ni = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule